// File: doc/BRIEF.md
# I2C Slave Interrupt Cause Register

This block turns decoded bus events from an I2C slave front end into five sticky cause bits and one interrupt line. The front end reports START, repeated START and STOP as single-cycle pulses. It also reports each received address byte, a flag saying whether the address belongs to this slave, and a pulse each time a data byte of a write is stored in the slave's memory. The block keeps a small record of the transfer in progress, so that the end of a transfer can be attributed to a matched read or write. It does not sample the bus lines, generate ACKs or store FIFO data.

A cause bit is set by hardware and cleared by software writing one to it. A mask register selects which causes drive the interrupt line. When address acceptance is on, a matched or general-call address byte is also offered to the write port of a receive FIFO that lives outside this block. A buffer-addressed mode changes when the write-stop cause fires: the first written byte carries the internal buffer address, so a write that carries only addresses does not count as a data write.

Top module: `i2c_slave_cause_reg`

Cause vector layout used everywhere below: bit 0 write-stop, bit 1 stop, bit 2 start, bit 3 address match, bit 4 general call.

## Requirements
- R1: After a synchronous reset, `cause`, `mask`, `irq` and `fifo_we` are all 0.
- R2: A `clr_we` cycle clears each cause bit whose `clr_data` bit is 1, visible one cycle later. If a hardware set hits the same bit in the same cycle, the bit ends up 1.
- R3: Start (bit 2) is set one cycle after an `evt_start` or `evt_rstart` pulse, unless `ec_am_en` and `ec_stretch` are both 1. In that case the pulse leaves bit 2 unchanged.
- R4: Address match (bit 3) is set one cycle after an `addr_valid` pulse with `addr_match` = 1.
- R5: General call (bit 4) is set one cycle after an `addr_valid` pulse whose `addr_byte` is 8'h00.
- R6: Stop (bit 1) is set one cycle after an `evt_stop` or `evt_rstart` pulse that ends a transfer whose address was own (`addr_match`) or general call, read or write. ACK or NACK of the address plays no part.
- R7: With `buf_mode` = 0, write-stop (bit 0) is set on the same ending event as R6 when the matched address had R/W bit (`addr_byte[0]`) = 0.
- R8: With `buf_mode` = 1, write-stop is set only if at least one `data_wr` pulse arrived during that matched write. A write with no such pulse leaves bit 0 unchanged.
- R9: Every START, repeated START and STOP discards the record of the previous transfer. The transfer after a repeated START is judged only by its own address byte.
- R10: `irq` equals the OR over bits of `cause & mask` and updates in the same cycle as `cause`. `mask` is loaded from `mask_data` on `mask_we`.
- R11: With `addr_accept` = 1, an `addr_valid` pulse carrying an own or general-call address gives a one-cycle `fifo_we` one cycle later, with `fifo_wdata` holding the address byte. Other addresses, or `addr_accept` = 0, leave `fifo_we` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_start | input | 1 | START detected (pulse) |
| evt_rstart | input | 1 | Repeated START detected (pulse) |
| evt_stop | input | 1 | STOP detected (pulse) |
| addr_valid | input | 1 | Address byte received (pulse) |
| addr_byte | input | 8 | Received address byte, R/W in bit 0 (1 = read) |
| addr_match | input | 1 | Address belongs to this slave |
| data_wr | input | 1 | Write data byte stored in memory (pulse) |
| buf_mode | input | 1 | Buffer-addressed mode |
| ec_am_en | input | 1 | Externally clocked address matching on |
| ec_stretch | input | 1 | Clock stretching used with external matching |
| addr_accept | input | 1 | Push matched address bytes to the RX FIFO |
| clr_we | input | 1 | Software write-one-to-clear strobe |
| clr_data | input | 5 | Bits to clear |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 5 | New mask value |
| cause | output | 5 | Sticky cause bits |
| mask | output | 5 | Interrupt mask |
| irq | output | 1 | Masked interrupt |
| fifo_we | output | 1 | RX FIFO write strobe |
| fifo_wdata | output | 8 | RX FIFO write data |

## Verification
A stale transfer record is the likely fault here. It shows up as a stop or write-stop cause that appears, or fails to appear, on the first STOP or repeated START after the faulty address phase. A lost or inverted set-versus-clear decision shows in `cause` one cycle after the colliding write. A mask or irq fault shows on `irq` in the cycle where the cause changes. The bench compares every output against a behavioural model on every cycle, so each fault is reported in the cycle it first reaches a port.

// File: rtl/i2c_cause_pkg.sv
package i2c_cause_pkg;
  localparam int NCAUSE   = 5;
  localparam int ADDR_W   = 8;
  localparam int C_WSTOP  = 0;
  localparam int C_STOP   = 1;
  localparam int C_START  = 2;
  localparam int C_MATCH  = 3;
  localparam int C_GCALL  = 4;
  typedef logic [NCAUSE-1:0] cause_t;
endpackage

// File: rtl/i2c_xfer_track.sv
module i2c_xfer_track (
  input  logic clk,
  input  logic rst,
  input  logic evt_start,
  input  logic evt_rstart,
  input  logic evt_stop,
  input  logic addr_valid,
  input  logic addr_hit,
  input  logic addr_rd,
  input  logic data_wr,
  input  logic buf_mode,
  output logic end_any,
  output logic end_wstop
);
  logic act_q, rd_q, wrote_q;
  logic xfer_end;

  assign xfer_end  = evt_stop | evt_rstart;
  assign end_any   = xfer_end & act_q;
  assign end_wstop = end_any & ~rd_q & (~buf_mode | wrote_q);

  always_ff @(posedge clk) begin
    if (rst || evt_start || evt_rstart || evt_stop) begin
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      wrote_q <= 1'b0;
    end else if (addr_valid) begin
      act_q   <= addr_hit;
      rd_q    <= addr_rd;
      wrote_q <= 1'b0;
    end else if (data_wr && act_q && !rd_q) begin
      wrote_q <= 1'b1;
    end
  end

  // R9
  fresh_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_start || evt_rstart) |=> !act_q);
endmodule

// File: rtl/i2c_cause_bank.sv
module i2c_cause_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_v,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] cause_q,
  output logic [N-1:0] cause_nxt
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr_i;
    assign clr_i        = clr_we & clr_data[i];
    assign cause_nxt[i] = set_v[i] | (cause_q[i] & ~clr_i);

    always_ff @(posedge clk) begin
      if (rst) cause_q[i] <= 1'b0;
      else     cause_q[i] <= cause_nxt[i];
    end

    // R2
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_v[i] |=> cause_q[i]);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!set_v[i] && !clr_i) |=> $stable(cause_q[i]));
  end
endmodule

// File: rtl/i2c_slave_cause_reg.sv
module i2c_slave_cause_reg
  import i2c_cause_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_start,
  input  logic              evt_rstart,
  input  logic              evt_stop,
  input  logic              addr_valid,
  input  logic [AW-1:0]     addr_byte,
  input  logic              addr_match,
  input  logic              data_wr,
  input  logic              buf_mode,
  input  logic              ec_am_en,
  input  logic              ec_stretch,
  input  logic              addr_accept,
  input  logic              clr_we,
  input  logic [NCAUSE-1:0] clr_data,
  input  logic              mask_we,
  input  logic [NCAUSE-1:0] mask_data,
  output logic [NCAUSE-1:0] cause,
  output logic [NCAUSE-1:0] mask,
  output logic              irq,
  output logic              fifo_we,
  output logic [AW-1:0]     fifo_wdata
);
  logic   gcall, hit, end_any, end_wstop;
  cause_t set_v, cause_nxt, mask_nxt;

  assign gcall = (addr_byte == '0);
  assign hit   = addr_match | gcall;

  i2c_xfer_track u_track (
    .clk(clk), .rst(rst),
    .evt_start(evt_start), .evt_rstart(evt_rstart), .evt_stop(evt_stop),
    .addr_valid(addr_valid), .addr_hit(hit), .addr_rd(addr_byte[0]),
    .data_wr(data_wr), .buf_mode(buf_mode),
    .end_any(end_any), .end_wstop(end_wstop)
  );

  always_comb begin
    set_v          = '0;
    set_v[C_WSTOP] = end_wstop;
    set_v[C_STOP]  = end_any;
    set_v[C_START] = (evt_start | evt_rstart) & ~(ec_am_en & ec_stretch);
    set_v[C_MATCH] = addr_valid & addr_match;
    set_v[C_GCALL] = addr_valid & gcall;
  end

  i2c_cause_bank #(.N(NCAUSE)) u_bank (
    .clk(clk), .rst(rst), .set_v(set_v),
    .clr_we(clr_we), .clr_data(clr_data),
    .cause_q(cause), .cause_nxt(cause_nxt)
  );

  assign mask_nxt = mask_we ? mask_data : mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask       <= '0;
      irq        <= 1'b0;
      fifo_we    <= 1'b0;
      fifo_wdata <= '0;
    end else begin
      mask    <= mask_nxt;
      irq     <= |(cause_nxt & mask_nxt);
      fifo_we <= addr_valid & addr_accept & hit;
      if (addr_valid) fifo_wdata <= addr_byte;
    end
  end

  // R10
  irq_consistent_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(cause & mask));
  // R11
  fifo_source_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> $past(addr_valid && addr_accept));
  // R3
  start_suppress_chk: assert property (@(posedge clk) disable iff (rst)
    ((evt_start || evt_rstart) && ec_am_en && ec_stretch && !cause[C_START])
      |=> !cause[C_START]);
endmodule

// File: tb/tb_i2c_slave_cause_reg.sv
module tb_i2c_slave_cause_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_start = 0, evt_rstart = 0, evt_stop = 0, addr_valid = 0;
  logic [7:0] addr_byte = 0;
  logic addr_match = 0, data_wr = 0, buf_mode = 0, ec_am_en = 0, ec_stretch = 0;
  logic addr_accept = 0, clr_we = 0, mask_we = 0;
  logic [4:0] clr_data = 0, mask_data = 0;
  logic [4:0] cause, mask;
  logic irq, fifo_we;
  logic [7:0] fifo_wdata;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  i2c_slave_cause_reg dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit [4:0] m_cause, m_mask;
  bit m_irq, m_fwe;
  bit [7:0] m_fdata;
  bit t_act, t_rd, t_wrote;

  always @(posedge clk) begin
    bit [4:0] s;
    bit ending, hit;
    if (rst) begin
      m_cause = 0; m_mask = 0; m_irq = 0; m_fwe = 0; m_fdata = 0;
      t_act = 0; t_rd = 0; t_wrote = 0;
    end else begin
      s = 0;
      hit = addr_match || (addr_byte == 8'h00);
      ending = evt_stop || evt_rstart;
      if (ending && t_act) begin
        s[1] = 1;
        if (!t_rd && (!buf_mode || t_wrote)) s[0] = 1;
      end
      if ((evt_start || evt_rstart) && !(ec_am_en && ec_stretch)) s[2] = 1;
      if (addr_valid && addr_match) s[3] = 1;
      if (addr_valid && addr_byte == 8'h00) s[4] = 1;
      if (clr_we) m_cause = m_cause & ~clr_data;
      m_cause = m_cause | s;
      if (mask_we) m_mask = mask_data;
      m_irq = (m_cause & m_mask) != 0;
      m_fwe = addr_valid && addr_accept && hit;
      if (addr_valid) m_fdata = addr_byte;
      if (evt_start || evt_rstart || evt_stop) begin
        t_act = 0; t_rd = 0; t_wrote = 0;
      end else if (addr_valid) begin
        t_act = hit; t_rd = addr_byte[0]; t_wrote = 0;
      end else if (data_wr && t_act && !t_rd) t_wrote = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cause[0] == m_cause[0], "R7/R8 write-stop", cause[0], m_cause[0]);
      chk(cause[1] == m_cause[1], "R6 stop", cause[1], m_cause[1]);
      chk(cause[2] == m_cause[2], "R3 start", cause[2], m_cause[2]);
      chk(cause[3] == m_cause[3], "R4 match", cause[3], m_cause[3]);
      chk(cause[4] == m_cause[4], "R5 gcall", cause[4], m_cause[4]);
      chk(mask == m_mask && irq == m_irq, "R10 mask/irq", {mask, irq}, {m_mask, m_irq});
      chk(fifo_we == m_fwe, "R11 fifo_we", fifo_we, m_fwe);
      if (m_fwe) chk(fifo_wdata == m_fdata, "R11 fifo_wdata", fifo_wdata, m_fdata);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();   evt_start = 1;  tick(); evt_start = 0;  endtask
  task automatic pulse_rstart();  evt_rstart = 1; tick(); evt_rstart = 0; endtask
  task automatic pulse_stop();    evt_stop = 1;   tick(); evt_stop = 0;   endtask
  task automatic pulse_data();    data_wr = 1;    tick(); data_wr = 0;    endtask
  task automatic send_addr(input logic [7:0] b, input logic m);
    addr_valid = 1; addr_byte = b; addr_match = m; tick();
    addr_valid = 0; addr_match = 0;
  endtask
  task automatic clear_all();
    clr_we = 1; clr_data = 5'h1F; tick(); clr_we = 0; clr_data = 0;
  endtask

  initial begin
    tick(3);
    // R1 reset state, sampled while reset still asserted after edges
    chk(cause == 0 && mask == 0 && irq == 0 && fifo_we == 0, "R1 reset",
        {cause, mask, irq, fifo_we}, 0);
    rst = 0;
    tick();
    chk(cause == 0 && irq == 0, "R1 after release", cause, 0);
    mask_we = 1; mask_data = 5'h1F; tick(); mask_we = 0;

    // matched write with data, STOP (R3 R4 R6 R7)
    pulse_start(); send_addr(8'h20, 1); pulse_data(); pulse_stop(); tick();
    chk(cause == 5'b01111, "R7 matched write stop", cause, 5'b01111);
    clear_all(); tick();
    chk(cause == 0 && irq == 0, "R2 clear all", cause, 0);

    // matched read: stop but no write-stop (R6)
    pulse_start(); send_addr(8'h21, 1); pulse_stop(); tick();
    chk(cause == 5'b01110, "R6 read stop", cause, 5'b01110);
    clear_all();

    // non-matching address: only start
    pulse_start(); send_addr(8'h40, 0); pulse_stop(); tick();
    chk(cause == 5'b00100, "R6 no match no stop", cause, 5'b00100);
    clear_all();

    // general call with address accept (R5 R11)
    addr_accept = 1;
    pulse_start(); send_addr(8'h00, 0);
    chk(fifo_we == 1 && fifo_wdata == 8'h00, "R11 gcall push", fifo_we, 1);
    pulse_stop(); tick();
    chk(cause == 5'b10111, "R5 general call", cause, 5'b10111);
    clear_all();
    pulse_start(); send_addr(8'h41, 0);
    chk(fifo_we == 0, "R11 no push on miss", fifo_we, 0);
    pulse_stop(); addr_accept = 0; clear_all();

    // buffer mode (R8)
    buf_mode = 1;
    pulse_start(); send_addr(8'h20, 1); pulse_stop(); tick();
    chk(cause[0] == 0, "R8 address-only write", cause[0], 0);
    clear_all();
    pulse_start(); send_addr(8'h20, 1); pulse_data(); pulse_stop(); tick();
    chk(cause[0] == 1, "R8 write with data", cause[0], 1);
    clear_all(); buf_mode = 0;

    // repeated START ends transfer, next judged fresh (R9)
    pulse_start(); send_addr(8'h20, 1); pulse_rstart(); tick();
    chk(cause[1:0] == 2'b11, "R9 rstart ends write", cause[1:0], 3);
    clear_all();
    send_addr(8'h53, 0); pulse_stop(); tick();
    chk(cause[1:0] == 2'b00, "R9 fresh after rstart", cause[1:0], 0);
    clear_all();

    // start suppression (R3)
    ec_am_en = 1; ec_stretch = 1; pulse_start(); tick();
    chk(cause[2] == 0, "R3 suppressed", cause[2], 0);
    ec_stretch = 0; pulse_start(); tick();
    chk(cause[2] == 1, "R3 not suppressed", cause[2], 1);
    ec_am_en = 0; clear_all();

    // set wins over clear in same cycle (R2)
    evt_start = 1; clr_we = 1; clr_data = 5'h1F; tick();
    evt_start = 0; clr_we = 0; clr_data = 0;
    chk(cause[2] == 1, "R2 set wins", cause[2], 1);

    // mask selects irq (R10)
    mask_we = 1; mask_data = 5'b00001; tick(); mask_we = 0;
    chk(irq == 0, "R10 masked off", irq, 0);
    mask_we = 1; mask_data = 5'b00100; tick(); mask_we = 0;
    chk(irq == 1, "R10 masked on", irq, 1);
    clear_all();
    chk(irq == 0, "R10 cleared", irq, 0);
    tick(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule